// File: doc/BRIEF.md
# Decimal-Bounded Saturating Accumulator Unit

This block is the execution unit of a small accumulator machine. It holds an accumulator and a backup register. Both are 11-bit two's complement words whose legal range is the decimal interval -999 to +999. An operation is applied when the execute strobe is high and the stall input is low. The operations are:

- add or subtract an operand,
- negate the accumulator,
- load an operand,
- exchange the accumulator and backup,
- copy the accumulator into the backup.

Results that leave the decimal range stick at the nearest limit. They never wrap, and they never fall into the codes -1024 to -1009, which are reserved for register and port addresses.

The unit also computes a relative branch target at all times. It adds a signed offset to the program counter and bounds the result to [0, length-1], where length is the number of instructions loaded at run time. A length of zero gives a target of 0. Zero, positive and negative flags are derived from the accumulator for the conditional branches of the surrounding control unit.

Top module: `dsat_alu_top`

## Requirements
- R1: While reset is held, and after it is released, the accumulator and the backup are both zero (op LOAD=3'd6 then SWAP=3'd4 brings back 0).
- R2: ADD (op 3'd1) sets ACC to ACC+operand, bounded to [-999, 999].
- R3: SUB (op 3'd2) sets ACC to ACC-operand, bounded to [-999, 999], including when the operand is negative.
- R4: NEG (op 3'd3) sets ACC to -ACC. Zero stays zero.
- R5: SWAP (op 3'd4) exchanges ACC and BAK in one operation.
- R6: SAVE (op 3'd5) copies ACC into BAK and leaves ACC unchanged.
- R7: LOAD (op 3'd6) sets ACC to the operand read as signed 11-bit and bounded to [-999, 999].
- R8: ACC never holds a value outside [-999, 999], so it never holds a reserved code -1024 to -1009.
- R9: Exactly one flag is high. flag_zero is high when ACC is 0, flag_pos when ACC > 0, and flag_neg when ACC < 0.
- R10: jmp_target equals pc + operand bounded to [0, prog_len-1], or 0 when prog_len is 0. The value is combinational and does not wrap.
- R11: An offset of 0 with pc < prog_len gives jmp_target = pc.
- R12: ACC and BAK keep their values when exec_en is low, when stall is high, and for NOP (op 3'd0) and BRANCH (op 3'd7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| exec_en | input | 1 | Apply op on this clock edge |
| stall | input | 1 | Blocks the operation while high |
| op | input | 3 | Operation code |
| operand | input | 11 | Signed operand or branch offset |
| pc | input | 4 | Current program counter |
| prog_len | input | 5 | Number of loaded instructions (0 to 16) |
| acc | output | 11 | Accumulator |
| flag_zero | output | 1 | ACC equals zero |
| flag_pos | output | 1 | ACC greater than zero |
| flag_neg | output | 1 | ACC less than zero |
| jmp_target | output | 4 | Bounded relative branch target |

## Verification
The bench loads all 2048 operand codes. Codes from -1024 to -1000 must stick at -999. A design that passed raw bits through would leave a reserved address code in the accumulator.

The add and subtract grids include the pairs 999+999, -999-999 and subtraction of negative values. A sum kept at 11 bits would wrap these results to the wrong sign instead of holding at the limit.

The branch sweep covers every program counter and every length, with zero, small and extreme offsets. An off-by-one bound would run past the last instruction, and a zero length mishandled would give a nonzero target.

The bench also issues swap, save and the hold cases of stall and disabled strobes. This exposes a design that let a stalled operation still update the backup register.

// File: rtl/dsat_pkg.sv
package dsat_pkg;
  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_ADD    = 3'd1,
    OP_SUB    = 3'd2,
    OP_NEG    = 3'd3,
    OP_SWAP   = 3'd4,
    OP_SAVE   = 3'd5,
    OP_LOAD   = 3'd6,
    OP_BRANCH = 3'd7
  } dsat_op_e;

  localparam int DSAT_DW      = 11;
  localparam int DSAT_MAX_MAG = 999;
  localparam int DSAT_PC_W    = 4;
endpackage

// File: rtl/dsat_rst_sync.sv
module dsat_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/dsat_addsub.sv
// Saturating adder/subtractor bounded to +/- MAX_MAG, computed two bits wider.
module dsat_addsub #(
  parameter int DW      = 11,
  parameter int MAX_MAG = 999
) (
  input  logic                 clk,
  input  logic                 rst_sn,
  input  logic signed [DW-1:0] a_i,
  input  logic signed [DW-1:0] b_i,
  input  logic                 sub_i,
  output logic signed [DW-1:0] res_o
);
  localparam int EW = DW + 2;
  localparam logic signed [EW-1:0] HI_E = EW'(MAX_MAG);
  localparam logic signed [EW-1:0] LO_E = -HI_E;
  localparam logic signed [DW-1:0] HI_D = DW'(MAX_MAG);
  localparam logic signed [DW-1:0] LO_D = -HI_D;

  logic signed [EW-1:0] a_e, b_e, raw_e;

  always_comb begin
    a_e   = EW'(a_i);
    b_e   = EW'(b_i);
    raw_e = sub_i ? (a_e - b_e) : (a_e + b_e);
    if (raw_e > HI_E)      res_o = HI_D;
    else if (raw_e < LO_E) res_o = LO_D;
    else                   res_o = raw_e[DW-1:0];
  end

  // R8: the adder output never leaves the decimal range
  a_r8_addsub_range: assert property (@(posedge clk) disable iff (!rst_sn)
    (res_o <= HI_D) && (res_o >= LO_D));
  // R2/R3: an in-range raw result is passed through unchanged
  a_r2_passthru: assert property (@(posedge clk) disable iff (!rst_sn)
    ((raw_e <= HI_E) && (raw_e >= LO_E)) |-> (EW'(res_o) == raw_e));
endmodule

// File: rtl/dsat_flags.sv
module dsat_flags #(
  parameter int DW = 11
) (
  input  logic                 clk,
  input  logic                 rst_sn,
  input  logic signed [DW-1:0] acc_i,
  output logic                 zero_o,
  output logic                 pos_o,
  output logic                 neg_o
);
  always_comb begin
    zero_o = (acc_i == '0);
    neg_o  = acc_i[DW-1];
    pos_o  = !zero_o && !acc_i[DW-1];
  end

  // R9: exactly one flag is set
  a_r9_one_flag: assert property (@(posedge clk) disable iff (!rst_sn)
    $countones({zero_o, pos_o, neg_o}) == 1);
endmodule

// File: rtl/dsat_jump.sv
// Relative branch target: pc + offset bounded to [0, len-1].
module dsat_jump #(
  parameter int DW   = 11,
  parameter int PC_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_sn,
  input  logic [PC_W-1:0]      pc_i,
  input  logic signed [DW-1:0] off_i,
  input  logic [PC_W:0]        len_i,
  output logic [PC_W-1:0]      tgt_o
);
  localparam int BW = ((DW > PC_W + 1) ? DW : PC_W + 1) + 2;

  logic signed [BW-1:0] pc_s, off_s, sum_s, last_s, bnd_s;

  always_comb begin
    pc_s   = $signed({{(BW-PC_W){1'b0}}, pc_i});
    off_s  = BW'(off_i);
    sum_s  = pc_s + off_s;
    if (len_i == '0) last_s = '0;
    else             last_s = $signed({{(BW-PC_W-1){1'b0}}, len_i}) - BW'(1);
    if (sum_s < 0)           bnd_s = '0;
    else if (sum_s > last_s) bnd_s = last_s;
    else                     bnd_s = sum_s;
    tgt_o = bnd_s[PC_W-1:0];
  end

  // R10: bounded target inside [0, last]
  a_r10_bounds: assert property (@(posedge clk) disable iff (!rst_sn)
    (bnd_s >= 0) && (bnd_s <= last_s));
  // R11: zero offset with pc inside the program keeps pc
  a_r11_zero_off: assert property (@(posedge clk) disable iff (!rst_sn)
    ((off_i == '0) && ({1'b0, pc_i} < len_i)) |-> (tgt_o == pc_i));
endmodule

// File: rtl/dsat_alu_top.sv
module dsat_alu_top #(
  parameter int DW      = dsat_pkg::DSAT_DW,
  parameter int MAX_MAG = dsat_pkg::DSAT_MAX_MAG,
  parameter int PC_W    = dsat_pkg::DSAT_PC_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exec_en,
  input  logic            stall,
  input  logic [2:0]      op,
  input  logic [DW-1:0]   operand,
  input  logic [PC_W-1:0] pc,
  input  logic [PC_W:0]   prog_len,
  output logic [DW-1:0]   acc,
  output logic            flag_zero,
  output logic            flag_pos,
  output logic            flag_neg,
  output logic [PC_W-1:0] jmp_target
);
  import dsat_pkg::*;

  localparam logic signed [DW-1:0] HI_D = DW'(MAX_MAG);
  localparam logic signed [DW-1:0] LO_D = -HI_D;

  logic                 rst_sn;
  logic signed [DW-1:0] acc_q, acc_d, bak_q, bak_d;
  logic signed [DW-1:0] as_a, as_b, as_res;
  logic                 as_sub, fire;
  dsat_op_e             op_e;

  dsat_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  // Operand steering for the single shared saturating adder
  always_comb begin
    op_e   = dsat_op_e'(op);
    as_a   = acc_q;
    as_b   = $signed(operand);
    as_sub = 1'b0;
    unique case (op_e)
      OP_SUB:  as_sub = 1'b1;
      OP_NEG:  begin as_a = '0; as_b = acc_q; as_sub = 1'b1; end
      OP_LOAD: as_a = '0;
      default: ;
    endcase
  end

  dsat_addsub #(.DW(DW), .MAX_MAG(MAX_MAG)) u_addsub (
    .clk(clk), .rst_sn(rst_sn),
    .a_i(as_a), .b_i(as_b), .sub_i(as_sub), .res_o(as_res)
  );

  // Next-state selection
  always_comb begin
    fire  = exec_en && !stall;
    acc_d = acc_q;
    bak_d = bak_q;
    unique case (op_e)
      OP_ADD, OP_SUB, OP_NEG, OP_LOAD: acc_d = as_res;
      OP_SWAP: begin acc_d = bak_q; bak_d = acc_q; end
      OP_SAVE: bak_d = acc_q;
      default: ;
    endcase
  end

  // State registers with explicit clock enable
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      acc_q <= '0;
      bak_q <= '0;
    end else if (fire) begin
      acc_q <= acc_d;
      bak_q <= bak_d;
    end
  end

  assign acc = acc_q;

  dsat_flags #(.DW(DW)) u_flags (
    .clk(clk), .rst_sn(rst_sn), .acc_i(acc_q),
    .zero_o(flag_zero), .pos_o(flag_pos), .neg_o(flag_neg)
  );

  dsat_jump #(.DW(DW), .PC_W(PC_W)) u_jump (
    .clk(clk), .rst_sn(rst_sn), .pc_i(pc), .off_i($signed(operand)),
    .len_i(prog_len), .tgt_o(jmp_target)
  );

  // R8: accumulator and backup stay in the decimal range
  a_r8_acc_range: assert property (@(posedge clk) disable iff (!rst_sn)
    (acc_q <= HI_D) && (acc_q >= LO_D) && (bak_q <= HI_D) && (bak_q >= LO_D));
  // R12: no state change without an unstalled strobe
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_sn)
    !(exec_en && !stall) |=> ($stable(acc_q) && $stable(bak_q)));
  // R4: negation sums with the previous value to zero
  a_r4_neg: assert property (@(posedge clk) disable iff (!rst_sn)
    (exec_en && !stall && op == 3'd3) |=> ((acc_q + $past(acc_q)) == '0));
  // R5: exchange
  a_r5_swap: assert property (@(posedge clk) disable iff (!rst_sn)
    (exec_en && !stall && op == 3'd4) |=> (acc_q == $past(bak_q) && bak_q == $past(acc_q)));
  // R6: save keeps ACC and copies it
  a_r6_save: assert property (@(posedge clk) disable iff (!rst_sn)
    (exec_en && !stall && op == 3'd5) |=> ($stable(acc_q) && bak_q == acc_q));
endmodule

// File: tb/dsat_alu_top_tb_top.sv
`timescale 1ns/1ps
module dsat_alu_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, exec_en, stall;
  logic [2:0]  op;
  logic [10:0] operand;
  logic [3:0]  pc;
  logic [4:0]  prog_len;
  logic [10:0] acc;
  logic        flag_zero, flag_pos, flag_neg;
  logic [3:0]  jmp_target;

  int n_checks = 0;
  int n_fails  = 0;

  always #2 clk = ~clk;

  dsat_alu_top dut_i (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .stall(stall), .op(op),
    .operand(operand), .pc(pc), .prog_len(prog_len), .acc(acc),
    .flag_zero(flag_zero), .flag_pos(flag_pos), .flag_neg(flag_neg),
    .jmp_target(jmp_target)
  );

  function automatic int sat(int x);
    if (x > 999)  return 999;
    if (x < -999) return -999;
    return x;
  endfunction

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_acc(string req, int exp);
    int ef;
    check(req, int'($signed(acc)), exp);
    ef = (exp == 0) ? 4 : (exp > 0 ? 2 : 1);
    check("R9 flags", int'({flag_zero, flag_pos, flag_neg}), ef);
  endtask

  // Drive at a falling edge, apply at the rising edge, sample at the next falling edge
  task automatic exec_op(logic [2:0] o, int v, logic st = 1'b0, logic en = 1'b1);
    @(negedge clk);
    op = o; operand = 11'(v); stall = st; exec_en = en;
    @(negedge clk);
    exec_en = 1'b0; stall = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; exec_en = 1'b0; stall = 1'b0; op = 3'd0; operand = '0;
    pc = '0; prog_len = '0;
    repeat (3) @(negedge clk);
    check_acc("R1 reset acc", 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_acc("R1 after release", 0);
    exec_op(3'd6, 321);
    exec_op(3'd4, 0);
    check_acc("R1 bak zero", 0);

    // R7 / R8: every operand code through LOAD
    for (int c = 0; c < 2048; c++) begin
      int sv;
      sv = (c >= 1024) ? c - 2048 : c;
      exec_op(3'd6, c);
      check_acc("R7 load", sat(sv));
      check("R8 no reserved code", int'(acc >= 11'h400 && acc <= 11'h40F), 0);
    end

    // R2 / R3: grids that hit both limits
    for (int a = -999; a <= 999; a += 37) begin
      for (int b = -999; b <= 999; b += 54) begin
        exec_op(3'd6, a);
        exec_op(3'd1, b);
        check_acc("R2 add", sat(a + b));
        exec_op(3'd6, a);
        exec_op(3'd2, b);
        check_acc("R3 sub", sat(a - b));
      end
    end

    // R4: negate across the whole range
    for (int a = -999; a <= 999; a++) begin
      exec_op(3'd6, a);
      exec_op(3'd3, 0);
      check_acc("R4 neg", -a);
    end

    // R5 / R6: save and swap
    for (int k = -999; k <= 999; k += 111) begin
      exec_op(3'd6, k);
      exec_op(3'd5, 0);
      check_acc("R6 save keeps acc", k);
      exec_op(3'd6, -k / 2);
      exec_op(3'd4, 0);
      check_acc("R5 swap to acc", k);
      exec_op(3'd4, 0);
      check_acc("R5 swap back", -k / 2);
    end

    // R12: holds
    exec_op(3'd6, 77);
    exec_op(3'd5, 0);
    exec_op(3'd6, 10);
    exec_op(3'd1, 100, 1'b0, 1'b0);
    check_acc("R12 en low", 10);
    exec_op(3'd1, 100, 1'b1, 1'b1);
    check_acc("R12 stall add", 10);
    exec_op(3'd4, 0, 1'b1, 1'b1);
    check_acc("R12 stall swap", 10);
    exec_op(3'd0, 500);
    check_acc("R12 nop", 10);
    exec_op(3'd7, 500);
    check_acc("R12 branch op", 10);
    exec_op(3'd4, 0);
    check_acc("R12 bak kept", 77);

    // R10 / R11: branch target sweep
    for (int l = 0; l <= 16; l++) begin
      for (int p = 0; p < 16; p++) begin
        for (int oi = 0; oi < 43; oi++) begin
          int off, e;
          off = (oi == 0) ? -999 : (oi == 42 ? 999 : oi - 21);
          pc = 4'(p); prog_len = 5'(l); operand = 11'(off);
          #1;
          if (l == 0) e = 0;
          else if (p + off < 0) e = 0;
          else if (p + off > l - 1) e = l - 1;
          else e = p + off;
          if (off == 0 && p < l) check("R11 zero offset", int'(jmp_target), p);
          else                   check("R10 target", int'(jmp_target), e);
        end
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule